// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides a fast clock by a programmable ratio using the pulse-swallow method. It contains a digital model of a dual-modulus prescaler, a swallow counter and a main counter. The prescaler base modulus M is either 32 or 64. While the swallow counter is non-zero, the prescaler counts M+1 input cycles per output tick. After that it counts M cycles per tick until the main counter has seen N ticks. One full output period is therefore M·N + A fast-clock cycles. At the end of each period the block emits a one-cycle comparison pulse, which a phase comparator can use.

A new setting is requested with a one-cycle `load` strobe together with `swallow_in`, `main_in` and `mod_sel`. The block accepts a request only if N ≥ 3 and A < N. If the request passes this check, it is held pending and becomes active at the next period boundary. If it fails, an error flag is raised and the block keeps running on its last accepted setting.

Top module: `pulse_swallow_div`

## Requirements
- R1: With `mod_sel`=0 (M=32), the number of fast-clock cycles between consecutive rising edges of `fp_pulse` is 32·N + A.
- R2: With `mod_sel`=1 (M=64), the number of fast-clock cycles between consecutive rising edges of `fp_pulse` is 64·N + A.
- R3: `mod_ctl` is high for exactly the first A·(M+1) cycles of each period, starting with the cycle in which `fp_pulse` is high. It never rises at any other point, and it stays low throughout the period when A=0.
- R4: `fp_pulse` is high for exactly one fast-clock cycle per period.
- R5: A setting that is accepted during a period does not change that period. It governs every period that starts at or after the next `fp_pulse`.
- R6: A load with N<3 or A≥N sets `cfg_err` from the cycle after the load and leaves the divide setting unchanged. The next valid load clears `cfg_err`. `cfg_err` changes only in the cycle after a load.
- R7: Synchronous reset sets A=0, N=3, M=32 and drives `fp_pulse` and `cfg_err` low, so the first periods are 96 cycles long with `mod_ctl` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that requests a new setting |
| mod_sel | input | 1 | Base modulus select: 0 gives 32/33, 1 gives 64/65 |
| swallow_in | input | 7 | Requested swallow count A |
| main_in | input | 11 | Requested main count N |
| fp_pulse | output | 1 | One-cycle pulse at the end of every period |
| mod_ctl | output | 1 | Modulus control: high selects M+1 |
| cfg_err | output | 1 | Last load requested an illegal setting |

## Verification
The hardest case to create from the ports is a load that arrives while a period is already running. To observe it, the period that was in progress must complete with the old ratio, and the very next period must use the new one. The stimulus waits for an output pulse, issues the load in the following cycle, and then expects one period at the old ratio followed by periods at the new ratio. Rejected loads are placed in the same position, so the checks show that the ratio stays the same across later boundaries. The extremes are also exercised: A=0, A=N−1 and the minimum N=3.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int A_W     = 7,
  parameter int N_W     = 11,
  parameter int M_LO    = 32,
  parameter int M_HI    = 64,
  parameter int RST_A   = 0,
  parameter int RST_N   = 3,
  parameter bit RST_SEL = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           mod_sel,
  input  logic [A_W-1:0] swallow_in,
  input  logic [N_W-1:0] main_in,
  output logic           fp_pulse,
  output logic           mod_ctl,
  output logic           cfg_err
);
  localparam int P_W = $clog2(M_HI + 1);
  localparam logic [P_W-1:0] M_LO_V = P_W'(M_LO);
  localparam logic [P_W-1:0] M_HI_V = P_W'(M_HI);
  localparam logic [N_W-1:0] N_MIN  = N_W'(3);

  logic [A_W-1:0] act_a, pnd_a, a_cnt;
  logic [N_W-1:0] act_n, pnd_n, n_cnt;
  logic           act_sel, pnd_sel;
  logic [P_W-1:0] p_cnt, m_eff, p_last;
  logic           tick, wrap, req_ok;

  assign mod_ctl = (a_cnt != '0);
  assign m_eff   = act_sel ? M_HI_V : M_LO_V;
  assign p_last  = mod_ctl ? m_eff : m_eff - P_W'(1);
  assign tick    = (p_cnt == p_last);
  assign wrap    = tick && (n_cnt == N_W'(1));
  assign req_ok  = (main_in >= N_MIN) && (N_W'(swallow_in) < main_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a    <= A_W'(RST_A);
      act_n    <= N_W'(RST_N);
      act_sel  <= RST_SEL;
      pnd_a    <= A_W'(RST_A);
      pnd_n    <= N_W'(RST_N);
      pnd_sel  <= RST_SEL;
      a_cnt    <= A_W'(RST_A);
      n_cnt    <= N_W'(RST_N);
      p_cnt    <= '0;
      fp_pulse <= 1'b0;
      cfg_err  <= 1'b0;
    end else begin
      fp_pulse <= wrap;
      if (load) begin
        if (req_ok) begin
          pnd_a   <= swallow_in;
          pnd_n   <= main_in;
          pnd_sel <= mod_sel;
          cfg_err <= 1'b0;
        end else begin
          cfg_err <= 1'b1;
        end
      end
      if (wrap) begin
        act_a   <= pnd_a;
        act_n   <= pnd_n;
        act_sel <= pnd_sel;
        a_cnt   <= pnd_a;
        n_cnt   <= pnd_n;
        p_cnt   <= '0;
      end else if (tick) begin
        p_cnt <= '0;
        n_cnt <= n_cnt - N_W'(1);
        if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      end else begin
        p_cnt <= p_cnt + P_W'(1);
      end
    end
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fp_pulse |=> !fp_pulse);

  a_r3_modctl_rise_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> fp_pulse);

  a_r3_modctl_start: assert property (@(posedge clk) disable iff (rst)
    fp_pulse |-> (mod_ctl == (act_a != '0)));

  a_r5_cfg_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !($stable(act_n) && $stable(act_a) && $stable(act_sel)) |-> fp_pulse);

  a_r6_err_only_on_load: assert property (@(posedge clk) disable iff (rst)
    !$past(load) |-> $stable(cfg_err));

  a_r1_prescaler_bound: assert property (@(posedge clk) disable iff (rst)
    p_cnt <= m_eff);

  a_r6_pending_legal: assert property (@(posedge clk) disable iff (rst)
    (pnd_n >= N_MIN) && (N_W'(pnd_a) < pnd_n));
endmodule

// File: tb/tb_pulse_swallow_div.sv
module tb_pulse_swallow_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic        mod_sel = 1'b0;
  logic [6:0]  swallow_in = '0;
  logic [10:0] main_in = 11'd3;
  logic        fp_pulse, mod_ctl, cfg_err;

  int checks = 0;
  int errors = 0;
  int q_per[$];
  int q_mc[$];
  int cur_per = 96;
  int cur_mc  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pulse_swallow_div dut (
    .clk(clk), .rst(rst), .load(load), .mod_sel(mod_sel),
    .swallow_in(swallow_in), .main_in(main_in),
    .fp_pulse(fp_pulse), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int  cnt = 0;
  int  mc = 0;
  bit  started = 0;
  bit  prev_fp = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (fp_pulse && started && !prev_fp && q_per.size() > 0) begin
        int ep, em;
        ep = q_per.pop_front();
        em = q_mc.pop_front();
        check(cnt == ep, "R1/R2/R5/R7 period", cnt, ep);
        check(mc == em, "R3 mod_ctl cycles", mc, em);
      end
      if (fp_pulse && prev_fp) check(0, "R4 pulse width", 2, 1);
      if (fp_pulse && !prev_fp) begin
        started = 1;
        cnt = 0;
        mc = 0;
      end
      cnt++;
      if (mod_ctl) mc++;
      prev_fp = fp_pulse;
    end
  end

  task automatic apply(input int a, input int n, input bit sel, input int k);
    bit valid;
    int m;
    valid = (n >= 3) && (a < n);
    m = sel ? 64 : 32;
    @(negedge clk iff fp_pulse);
    #1;
    q_per.push_back(cur_per);
    q_mc.push_back(cur_mc);
    if (valid) begin
      cur_per = m * n + a;
      cur_mc  = a * (m + 1);
    end
    for (int i = 0; i < k; i++) begin
      q_per.push_back(cur_per);
      q_mc.push_back(cur_mc);
    end
    swallow_in = 7'(a);
    main_in = 11'(n);
    mod_sel = sel;
    load = 1'b1;
    @(negedge clk);
    check(cfg_err == !valid, "R6 cfg_err", int'(cfg_err), int'(!valid));
    #1 load = 1'b0;
    wait (q_per.size() == 0);
    @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fp_pulse == 0, "R7 reset fp_pulse", int'(fp_pulse), 0);
    check(mod_ctl == 0, "R7 reset mod_ctl", int'(mod_ctl), 0);
    check(cfg_err == 0, "R7 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;
    @(negedge clk iff fp_pulse);
    apply(5, 10, 1'b0, 2);     // R1 R5 R7
    apply(7, 20, 1'b1, 2);     // R2
    apply(0, 3, 1'b0, 2);      // R3 A=0, minimum N
    apply(99, 100, 1'b1, 2);   // R2 R3 A=N-1
    apply(0, 2, 1'b0, 2);      // R6 N<3 rejected
    apply(50, 50, 1'b1, 1);    // R6 A>=N rejected
    apply(2, 3, 1'b0, 2);      // R6 clear, R1
    check(cfg_err == 0, "R6 cleared", int'(cfg_err), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule